// File: doc/BRIEF.md
# MFM Write Encoder with Mark and Checksum Commands

This block turns a stream of controller bytes into the cell sequence written to a floppy-style medium using modified frequency modulation. Each byte is offered on a valid/ready handshake and becomes sixteen cells, with one cell sent on every pulse of a cell-rate enable. Most byte values pass through as data. Three reserved values are commands instead. One produces an A1 mark whose clock pulse is removed. One produces a C2 mark with a removed clock. One appends the running 16-bit checksum.

The checksum register lives inside the encoder. An A1 mark command presets it to the value that three A1 marks would leave, so a header or data field can be protected without feeding the marks through the checksum logic. A one-byte holding register sits behind the handshake. While the encoder is shifting a byte, the next byte waits there, and the cell stream has no gaps as long as the source keeps up.

Top module: `mfm_wr_enc`

## Requirements
- R1: Each data bit, most significant first, becomes a clock cell followed by a data cell. The data cell equals the bit. The clock cell is 1 only when both this bit and the previous data bit are 0. The previous bit carries across byte boundaries and idle time, and it is 0 after reset. An ordinary A1 byte yields 0100010010101001 (first cell on the left).
- R2: Input values 00 to F4 and F8 to FF are encoded as plain data and fed into the checksum.
- R3: Input F5 emits A1 with the clock cell of data bit 2 forced to 0, giving 0100010010001001, and sets the checksum register to CDB4.
- R4: Input F6 emits C2 with the clock cell of data bit 3 forced to 0, giving 0101001000100100, and leaves the checksum unchanged.
- R5: Input F7 emits the checksum as two ordinary data bytes, high byte first, and does not alter the checksum. The checksum is CRC-16 with polynomial 0x1021, bit-serial, most significant bit first, and reset value FFFF.
- R6: After F7 is accepted, in_ready stays low until the last cell of the low checksum byte has been emitted, and rises right after that cell.
- R7: cell_out and cell_act change only on clock edges where cell_en is high. cell_act is 1 while a byte is being emitted. When no byte is available, cell_act and cell_out are 0. Bytes that are accepted ahead of time give a stream with no gaps.
- R8: After reset, in_ready is 1 and cell_act and cell_out are 0.
- R9: A byte is taken on a clock edge with in_valid and in_ready both high. While one byte waits behind the byte being shifted, in_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cell_en | input | 1 | Cell-rate enable, one output cell per high cycle |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Data byte or command code |
| in_ready | output | 1 | Encoder can take a byte |
| cell_out | output | 1 | Current MFM cell |
| cell_act | output | 1 | cell_out carries a cell of a byte |

## Verification
A corrupted previous-bit state shows up in the first clock cell of the next byte that starts with a 0 bit, within two cell times of the fault. A corrupted checksum stays hidden until the next F7. It then shows as wrong data cells in the two checksum bytes, so the bench runs preset, mark, data and checksum sequences back to back. A fault in the holding register or the command sequencing shows as a missing, repeated or misplaced sixteen-cell group. It also shows as in_ready rising inside the checksum window, on the first cell where the stream departs from the reference.

// File: rtl/mfm_enc_pkg.sv
`timescale 1ns/1ps
package mfm_enc_pkg;
  localparam int BYTE_W = 8;
  localparam int CELL_W = 2 * BYTE_W;
  localparam int CRC_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    K_DATA    = 3'd0,
    K_SYNC_A1 = 3'd1,
    K_SYNC_C2 = 3'd2,
    K_CRC_HI  = 3'd3,
    K_CRC_LO  = 3'd4
  } tok_kind_e;

  typedef struct packed {
    tok_kind_e             kind;
    logic [BYTE_W-1:0]     val;
  } tok_t;
endpackage

// File: rtl/mfm_tok_src.sv
`timescale 1ns/1ps
// Input handshake, one-byte holding slot, command decode and
// sequencing of the two checksum bytes.
module mfm_tok_src
  import mfm_enc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_SYNC_A1 = 8'hF5,
  parameter logic [BYTE_W-1:0] CMD_SYNC_C2 = 8'hF6,
  parameter logic [BYTE_W-1:0] CMD_CRC     = 8'hF7,
  parameter logic [BYTE_W-1:0] A1_VAL      = 8'hA1,
  parameter logic [BYTE_W-1:0] C2_VAL      = 8'hC2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              take,
  input  logic              last_cell,
  input  logic [CRC_W-1:0]  crc_q,
  output logic              tok_avail,
  output tok_t              tok
);

  logic              hold_full_q, hold_full_n;
  logic [BYTE_W-1:0] hold_byte_q, hold_byte_n;
  logic              lo_pend_q, lo_pend_n;
  logic              lo_busy_q, lo_busy_n;
  logic [BYTE_W-1:0] lo_byte_q, lo_byte_n;
  logic              accept;
  logic [BYTE_W-1:0] src_byte;

  function automatic tok_t classify(input logic [BYTE_W-1:0] b,
                                    input logic [CRC_W-1:0]  c);
    tok_t t;
    if (b == CMD_SYNC_A1) begin
      t.kind = K_SYNC_A1;
      t.val  = A1_VAL;
    end else if (b == CMD_SYNC_C2) begin
      t.kind = K_SYNC_C2;
      t.val  = C2_VAL;
    end else if (b == CMD_CRC) begin
      t.kind = K_CRC_HI;
      t.val  = c[CRC_W-1 -: BYTE_W];
    end else begin
      t.kind = K_DATA;
      t.val  = b;
    end
    return t;
  endfunction

  assign in_ready  = !hold_full_q && !lo_pend_q && !lo_busy_q;
  assign accept    = in_valid && in_ready;
  assign tok_avail = lo_pend_q || hold_full_q || accept;
  assign src_byte  = hold_full_q ? hold_byte_q : in_byte;

  always_comb begin
    if (lo_pend_q) begin
      tok.kind = K_CRC_LO;
      tok.val  = lo_byte_q;
    end else begin
      tok = classify(src_byte, crc_q);
    end
  end

  always_comb begin
    hold_full_n = hold_full_q;
    hold_byte_n = hold_byte_q;
    lo_pend_n   = lo_pend_q;
    lo_busy_n   = lo_busy_q;
    lo_byte_n   = lo_byte_q;
    if (take) begin
      if (lo_pend_q) begin
        lo_pend_n = 1'b0;
        lo_busy_n = 1'b1;
      end else begin
        hold_full_n = 1'b0;
        if (tok.kind == K_CRC_HI) begin
          lo_pend_n = 1'b1;
          lo_byte_n = crc_q[BYTE_W-1:0];
        end
      end
    end else begin
      if (accept) begin
        hold_full_n = 1'b1;
        hold_byte_n = in_byte;
      end
      if (last_cell) begin
        lo_busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_byte_q <= '0;
      lo_pend_q   <= 1'b0;
      lo_busy_q   <= 1'b0;
      lo_byte_q   <= '0;
    end else begin
      hold_full_q <= hold_full_n;
      hold_byte_q <= hold_byte_n;
      lo_pend_q   <= lo_pend_n;
      lo_busy_q   <= lo_busy_n;
      lo_byte_q   <= lo_byte_n;
    end
  end

endmodule

// File: rtl/mfm_crc16.sv
`timescale 1ns/1ps
// Byte-wide checksum register: bit-serial CRC unrolled over one byte.
module mfm_crc16
  import mfm_enc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY   = 16'h1021,
  parameter logic [CRC_W-1:0] INIT   = 16'hFFFF,
  parameter logic [CRC_W-1:0] PRESET = 16'hCDB4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              preset,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);

  logic [CRC_W-1:0] crc_step;
  logic [CRC_W-1:0] crc_n;

  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_q;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ din[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc_step = c;
  end

  always_comb begin
    crc_n = crc_q;
    if (preset)   crc_n = PRESET;
    else if (upd) crc_n = crc_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_n;
  end

endmodule

// File: rtl/mfm_cell_coder.sv
`timescale 1ns/1ps
// Combinational byte-to-cells expansion with per-kind clock removal.
module mfm_cell_coder
  import mfm_enc_pkg::*;
#(
  parameter int A1_GAP_CELL = 5,
  parameter int C2_GAP_CELL = 7
) (
  input  tok_t              tok,
  input  logic              prev_bit,
  output logic [CELL_W-1:0] cells,
  output logic              last_bit
);

  logic [BYTE_W:0] chain;

  assign chain[BYTE_W] = prev_bit;

  genvar g;
  generate
    for (g = BYTE_W - 1; g >= 0; g--) begin : g_bit
      logic d;
      logic clk_cell;
      assign d = tok.val[g];
      assign chain[g] = d;
      if (2 * g + 1 == A1_GAP_CELL && 2 * g + 1 == C2_GAP_CELL) begin : g_both
        assign clk_cell = !chain[g+1] && !d &&
                          (tok.kind != K_SYNC_A1) && (tok.kind != K_SYNC_C2);
      end else if (2 * g + 1 == A1_GAP_CELL) begin : g_a1
        assign clk_cell = !chain[g+1] && !d && (tok.kind != K_SYNC_A1);
      end else if (2 * g + 1 == C2_GAP_CELL) begin : g_c2
        assign clk_cell = !chain[g+1] && !d && (tok.kind != K_SYNC_C2);
      end else begin : g_plain
        assign clk_cell = !chain[g+1] && !d;
      end
      assign cells[2*g+1] = clk_cell;
      assign cells[2*g]   = d;
    end
  endgenerate

  assign last_bit = chain[0];

endmodule

// File: rtl/mfm_cell_shift.sv
`timescale 1ns/1ps
// Cell serialiser: one cell per enable, fetches a new byte when empty.
module mfm_cell_shift
  import mfm_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_en,
  input  logic              tok_avail,
  input  logic [CELL_W-1:0] cells,
  input  logic              last_bit,
  output logic              take,
  output logic              last_cell,
  output logic              cell_out,
  output logic              cell_act,
  output logic              prev_bit
);

  localparam int CNT_W = $clog2(CELL_W);
  localparam logic [CNT_W-1:0] REM_FULL = CNT_W'(CELL_W - 1);

  logic [CELL_W-2:0] sh_q, sh_n;
  logic [CNT_W-1:0]  rem_q, rem_n;
  logic              out_q, out_n;
  logic              act_q, act_n;
  logic              prev_q, prev_n;
  logic              busy;

  assign busy      = (rem_q != '0);
  assign take      = cell_en && !busy && tok_avail;
  assign last_cell = cell_en && (rem_q == CNT_W'(1));

  always_comb begin
    sh_n   = sh_q;
    rem_n  = rem_q;
    out_n  = out_q;
    act_n  = act_q;
    prev_n = prev_q;
    if (cell_en) begin
      if (busy) begin
        out_n = sh_q[CELL_W-2];
        sh_n  = {sh_q[CELL_W-3:0], 1'b0};
        rem_n = rem_q - CNT_W'(1);
        act_n = 1'b1;
      end else if (tok_avail) begin
        out_n  = cells[CELL_W-1];
        sh_n   = cells[CELL_W-2:0];
        rem_n  = REM_FULL;
        act_n  = 1'b1;
        prev_n = last_bit;
      end else begin
        out_n = 1'b0;
        act_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      out_q  <= 1'b0;
      act_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      rem_q  <= rem_n;
      out_q  <= out_n;
      act_q  <= act_n;
      prev_q <= prev_n;
    end
  end

  assign cell_out = out_q;
  assign cell_act = act_q;
  assign prev_bit = prev_q;

endmodule

// File: rtl/mfm_wr_enc.sv
`timescale 1ns/1ps
module mfm_wr_enc
  import mfm_enc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_SYNC_A1 = 8'hF5,
  parameter logic [BYTE_W-1:0] CMD_SYNC_C2 = 8'hF6,
  parameter logic [BYTE_W-1:0] CMD_CRC     = 8'hF7,
  parameter logic [CRC_W-1:0]  CRC_POLY    = 16'h1021,
  parameter logic [CRC_W-1:0]  CRC_INIT    = 16'hFFFF,
  parameter logic [CRC_W-1:0]  CRC_PRESET  = 16'hCDB4,
  parameter int                RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_en,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              cell_out,
  output logic              cell_act
);

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_core_n;
  logic                  take;
  logic                  last_cell;
  logic                  tok_avail;
  tok_t                  tok;
  tok_kind_e             tok_kind;
  logic [CRC_W-1:0]      crc_q;
  logic [CELL_W-1:0]     cells;
  logic                  last_bit;
  logic                  prev_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[RST_STAGES-1];

  assign tok_kind = tok.kind;

  mfm_tok_src #(
    .CMD_SYNC_A1 (CMD_SYNC_A1),
    .CMD_SYNC_C2 (CMD_SYNC_C2),
    .CMD_CRC     (CMD_CRC)
  ) i_src (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .take      (take),
    .last_cell (last_cell),
    .crc_q     (crc_q),
    .tok_avail (tok_avail),
    .tok       (tok)
  );

  mfm_crc16 #(
    .POLY   (CRC_POLY),
    .INIT   (CRC_INIT),
    .PRESET (CRC_PRESET)
  ) i_crc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .upd    (take && (tok_kind == K_DATA)),
    .preset (take && (tok_kind == K_SYNC_A1)),
    .din    (tok.val),
    .crc_q  (crc_q)
  );

  mfm_cell_coder i_coder (
    .tok      (tok),
    .prev_bit (prev_bit),
    .cells    (cells),
    .last_bit (last_bit)
  );

  mfm_cell_shift i_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cell_en   (cell_en),
    .tok_avail (tok_avail),
    .cells     (cells),
    .last_bit  (last_bit),
    .take      (take),
    .last_cell (last_cell),
    .cell_out  (cell_out),
    .cell_act  (cell_act),
    .prev_bit  (prev_bit)
  );

endmodule

// File: rtl/mfm_wr_enc_chk.sv
`timescale 1ns/1ps
module mfm_wr_enc_chk
  import mfm_enc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_CRC    = 8'hF7,
  parameter logic [CRC_W-1:0]  CRC_PRESET = 16'hCDB4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cell_en,
  input logic              cell_out,
  input logic              cell_act,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_byte,
  input logic              take,
  input tok_kind_e         tok_kind,
  input logic [CRC_W-1:0]  crc_q
);

  // R1: the MFM rule never yields two 1 cells in a row
  p_no_double_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && cell_act && cell_out) |=> !cell_out);

  // R7: outputs move only on cell enable edges
  p_hold_between_cells_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_en |=> ($stable(cell_out) && $stable(cell_act)));

  // R3: sync A1 leaves the preset in the checksum register
  p_sync_preset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tok_kind == K_SYNC_A1) |=> (crc_q == CRC_PRESET));

  // R4: sync C2 does not touch the checksum
  p_c2_keeps_crc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tok_kind == K_SYNC_C2) |=> $stable(crc_q));

  // R5: emitting checksum bytes does not change the checksum
  p_crc_emit_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (tok_kind == K_CRC_HI || tok_kind == K_CRC_LO)) |=> $stable(crc_q));

  // R6: accepting the checksum command closes the input
  p_crc_cmd_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_byte == CMD_CRC) |=> !in_ready);

endmodule

bind mfm_wr_enc mfm_wr_enc_chk #(
  .CMD_CRC    (CMD_CRC),
  .CRC_PRESET (CRC_PRESET)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .cell_en  (cell_en),
  .cell_out (cell_out),
  .cell_act (cell_act),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_byte  (in_byte),
  .take     (take),
  .tok_kind (tok_kind),
  .crc_q    (crc_q)
);

// File: tb/test_mfm_wr_enc.sv
`timescale 1ns/1ps
module test_mfm_wr_enc;

  logic       clk;
  logic       rst_n;
  logic       cell_en;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       in_ready;
  logic       cell_out;
  logic       cell_act;

  int errors = 0;
  int checks = 0;
  int ce_div = 1;
  int ce_cnt = 0;
  bit ce_seen = 0;
  bit running = 0;
  bit done = 0;

  // reference model state
  bit         exp_q[$];
  string      tag_q[$];
  bit         m_prev = 0;
  logic [15:0] m_crc = 16'hFFFF;
  int         pushed = 0;
  int         crc_first = -100;

  // observation state
  int          obs_total = 0;
  int          obs_cnt = 0;
  logic [15:0] obs_word = '0;
  logic [15:0] words[$];

  mfm_wr_enc i_mfm_wr_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cell_en  (cell_en),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .in_ready (in_ready),
    .cell_out (cell_out),
    .cell_act (cell_act)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [7:0] dec(input logic [15:0] w);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = w[2*i];
    return r;
  endfunction

  // kind: 0 data, 1 A1 with missing clock at bit 2, 2 C2 with missing clock at bit 3
  task automatic emit(input logic [7:0] v, input int kind, input string tag);
    for (int i = 7; i >= 0; i--) begin
      bit d;
      bit c;
      d = v[i];
      c = !m_prev && !d;
      if ((kind == 1 && i == 2) || (kind == 2 && i == 3)) c = 0;
      exp_q.push_back(c);
      tag_q.push_back(tag);
      exp_q.push_back(d);
      tag_q.push_back(tag);
      pushed += 2;
      m_prev = d;
    end
  endtask

  task automatic model_push(input logic [7:0] b);
    if (b == 8'hF5) begin
      emit(8'hA1, 1, "R3");
      m_crc = 16'hCDB4;
    end else if (b == 8'hF6) begin
      emit(8'hC2, 2, "R4");
    end else if (b == 8'hF7) begin
      crc_first = pushed;
      emit(m_crc[15:8], 0, "R5");
      emit(m_crc[7:0], 0, "R5");
    end else begin
      emit(b, 0, "R2");
      m_crc = crc_step(m_crc, b);
    end
  endtask

  // cell enable driver
  initial begin
    cell_en = 0;
    forever begin
      @(negedge clk);
      #1;
      if (ce_cnt >= ce_div - 1) begin
        cell_en = 1;
        ce_cnt = 0;
      end else begin
        cell_en = 0;
        ce_cnt++;
      end
    end
  end

  initial forever begin
    @(posedge clk);
    ce_seen = cell_en;
  end

  // per-cell monitor against the reference model
  initial forever begin
    @(negedge clk);
    if (running && ce_seen) begin
      if (cell_act) begin
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected cell", 1, 0);
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          // R1 cell rule applied to every tagged cell
          check(cell_out == e, t, $sformatf("cell %0d", obs_total), cell_out, e);
        end
        if (obs_total >= crc_first && obs_total < crc_first + 31)
          check(in_ready == 0, "R6", "ready inside checksum window", in_ready, 0);
        else if (obs_total == crc_first + 31)
          check(in_ready == 1, "R6", "ready after last checksum cell", in_ready, 1);
        obs_word = {obs_word[14:0], cell_out};
        obs_cnt++;
        obs_total++;
        if (obs_cnt == 16) begin
          words.push_back(obs_word);
          obs_cnt = 0;
        end
      end else begin
        check(exp_q.size() == 0, "R7", "gap in cell stream", exp_q.size(), 0);
        check(cell_out == 0, "R7", "idle cell level", cell_out, 0);
      end
    end
  end

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    #1;
    in_valid = 1;
    in_byte = b;
    while (in_ready !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    model_push(b);
    @(posedge clk);
  endtask

  task automatic end_burst();
    @(negedge clk);
    #1;
    in_valid = 0;
    in_byte = 8'h00;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (8 * ce_div + 4) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R7", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int w0;
    logic [15:0] ref_crc;
    rst_n = 0;
    in_valid = 0;
    in_byte = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    running = 1;
    check(in_ready == 1, "R8", "ready after reset", in_ready, 1);
    check(cell_act == 0, "R8", "active after reset", cell_act, 0);
    check(cell_out == 0, "R8", "cell after reset", cell_out, 0);

    // burst 1: literal mark patterns, full-rate cells
    ce_div = 1;
    w0 = words.size();
    put_byte(8'hA1);
    put_byte(8'hF5);
    put_byte(8'hF6);
    end_burst();
    drain();
    check(words[w0] == 16'b0100010010101001, "R1", "plain A1 cells", words[w0], 16'b0100010010101001);
    check(words[w0+1] == 16'b0100010010001001, "R3", "sync A1 cells", words[w0+1], 16'b0100010010001001);
    check(words[w0+2] == 16'b0101001000100100, "R4", "sync C2 cells", words[w0+2], 16'b0101001000100100);

    // burst 2: header preset and checksum, slower cells
    ce_div = 3;
    w0 = words.size();
    put_byte(8'hF5);
    put_byte(8'hF5);
    put_byte(8'hF5);
    put_byte(8'hFE);
    put_byte(8'hF7);
    put_byte(8'h00);
    end_burst();
    drain();
    ref_crc = 16'hFFFF;
    ref_crc = crc_step(ref_crc, 8'hA1);
    ref_crc = crc_step(ref_crc, 8'hA1);
    ref_crc = crc_step(ref_crc, 8'hA1);
    ref_crc = crc_step(ref_crc, 8'hFE);
    check({dec(words[w0+4]), dec(words[w0+5])} == ref_crc, "R5",
          "checksum after three sync A1 and FE", {dec(words[w0+4]), dec(words[w0+5])}, ref_crc);
    check(dec(words[w0+6]) == 8'h00, "R5", "byte after checksum is data", dec(words[w0+6]), 0);

    // burst 3: C2 leaves the preset untouched
    w0 = words.size();
    put_byte(8'hF5);
    put_byte(8'hF6);
    put_byte(8'hF7);
    end_burst();
    drain();
    check({dec(words[w0+2]), dec(words[w0+3])} == 16'hCDB4, "R4",
          "checksum after sync C2", {dec(words[w0+2]), dec(words[w0+3])}, 16'hCDB4);

    // burst 4: data range, address mark codes, holding slot
    w0 = words.size();
    put_byte(8'h00);
    put_byte(8'hFF);
    @(negedge clk);
    #1;
    check(in_ready == 0, "R9", "ready while a byte waits", in_ready, 0);
    put_byte(8'h55);
    put_byte(8'hAA);
    put_byte(8'h29);
    put_byte(8'hF8);
    put_byte(8'hFB);
    put_byte(8'hFC);
    put_byte(8'hF4);
    put_byte(8'h80);
    put_byte(8'h01);
    put_byte(8'hF7);
    put_byte(8'h14);
    end_burst();
    drain();
    check(dec(words[w0+5]) == 8'hF8, "R2", "F8 passes as data", dec(words[w0+5]), 8'hF8);
    check(dec(words[w0+8]) == 8'hF4, "R2", "F4 passes as data", dec(words[w0+8]), 8'hF4);
    check(cell_act == 0, "R7", "idle after burst", cell_act, 0);

    // burst 5: previous bit carried over idle time, full-rate cells
    ce_div = 1;
    put_byte(8'h00);
    put_byte(8'h00);
    put_byte(8'hF7);
    end_burst();
    drain();
    check(exp_q.size() == 0, "R7", "all expected cells seen", exp_q.size(), 0);

    finish_run();
  end

endmodule